// File: doc/BRIEF.md
# Host Mailbox and Shared-Memory Port

This block is a byte-wide slave port through which a host processor reaches the local RAM of an embedded controller and trades interrupts with it. Each host access carries a five-bit offset. The offset selects one of five targets: the two bytes of a 16-bit address pointer, a combined status/control register, a data window into RAM at the pointer, or a window onto sixteen peripheral device registers. An access to the RAM window can step the pointer forward on its own, so the host can stream a buffer through one offset.

The status register drives the reset line of the embedded CPU. It also rings a doorbell toward the embedded side and acknowledges two host interrupt flags. The embedded side raises those flags through a separate write strobe, and the host interrupt output stays high while either flag is set. In bypass mode the peripheral window passes host accesses straight through. Outside bypass mode the host is shut out of that window, and the status read-back takes a different shape.

Host requests use a valid/ready handshake. The port accepts a request only when ready is high, and holds at most one access in flight. Ready stays low until that access finishes. Every accepted read returns exactly one `rsp_valid` pulse, and writes return nothing. The response channel has no back-pressure, so the host must take the data in the cycle it is offered. The RAM request uses valid/ready. The memory returns read data in the cycle after it accepts a request. The peripheral port always accepts and uses the same one-cycle read latency.

Top module: `mbx_host_port`

## Requirements
- R1: Offset decode is by priority. Bit 4 selects the peripheral window, with bits 3:0 as the register index. Otherwise bit 2 selects the RAM window, then bit 1 selects status, then bit 0 selects the pointer low byte. An offset with all of these bits clear selects the pointer high byte.
- R2: A write to a pointer byte replaces that byte. A read of a pointer byte returns it. Offset 0 is the high byte and offset 1 is the low byte.
- R3: A RAM window access uses the pointer as its address. When status bit 1 is set, the pointer advances by one exactly once when the memory accepts the access, wrapping from 0xFFFF to 0x0000. When bit 1 is clear the pointer is left unchanged.
- R4: A status write stores data bits 2:1. `cpu_reset_n` follows stored bit 2: 0 holds the embedded CPU in reset and 1 releases it.
- R5: A status write with data bit 3 set gives a one-cycle `emb_doorbell` pulse in the cycle after acceptance. Bit 3 is never stored and always reads back as 0.
- R6: Status bits 5:4 are host interrupt flags. A host status write clears each flag whose data bit is 1. `host_irq` is high in the cycle after any flag is set and low once both are clear.
- R7: An `emb_wr` strobe sets flag 4 from `emb_wdata` bit 2 and flag 5 from bit 3. `emb_rd` presents flags 5:4 on bits 3:2, with the other bits 0.
- R8: When a host clear and an embedded set hit the same flag in the same cycle, the set wins.
- R9: Status bit 6 is `periph_int` registered one cycle, and bit 7 reads as 1. In bypass mode a status read returns the status byte with bit 0 forced to 1. In normal mode it returns bits 5:0, with bit 7 set to 1 and bit 6 set to 0.
- R10: The peripheral window drives `per_valid` only for accesses accepted while `bypass` is high. In normal mode a host read of the window returns 0 and a host write is dropped.
- R11: After `rst_n` the status reads 0x80, the pointer is 0, `cpu_reset_n` and `host_irq` are low, and `req_ready` is high. A `port_clr` pulse clears bits 5:2, which puts the CPU in reset and drops `host_irq`, and keeps bits 7:6 and 1:0.
- R12: While a RAM request waits for `ram_ready`, `ram_valid`, `ram_addr` and `ram_wdata` hold steady and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_clr | input | 1 | Synchronous controller reset pulse |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Port can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Host offset |
| req_wdata | input | 8 | Host write data |
| rsp_valid | output | 1 | Read data valid, one cycle per read |
| rsp_data | output | 8 | Read data |
| ram_valid | output | 1 | RAM request valid |
| ram_ready | input | 1 | RAM accepts the request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address (the pointer) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, cycle after acceptance |
| per_valid | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write enable |
| per_idx | output | 4 | Peripheral register index |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data, cycle after strobe |
| bypass | input | 1 | Bypass mode select |
| periph_int | input | 1 | Peripheral interrupt level |
| emb_wr | input | 1 | Embedded-side flag-set strobe |
| emb_wdata | input | 8 | Embedded-side flag-set data |
| emb_rd | output | 8 | Host flags seen by the embedded side |
| emb_doorbell | output | 1 | Doorbell pulse toward the embedded CPU |
| cpu_reset_n | output | 1 | Embedded CPU reset, active low |
| host_irq | output | 1 | Host interrupt |

## Verification
The decode is tried with offsets that set several select bits at once, such as 0x05, 0x06, 0x03 and 0x17. Each of these resolves to a different target than a lower-priority bit would pick, so a wrong priority order returns the wrong data. RAM streaming is run with auto-increment on and off, across the 0xFFFF wrap, and under a stalled `ram_ready`. Together these separate an increment taken per completed access from one taken per request cycle or skipped. The flag logic is driven with host-only clears, embedded-only sets and a set and clear in the same cycle, to show that the set wins. Status reads are repeated in both modes with `periph_int` high, which exposes any swap of the two read-back formats.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;

  // status bit positions (host-visible layout)
  localparam int SB_AINC = 1;
  localparam int SB_RUN  = 2;
  localparam int SB_BELL = 3;
  localparam int SB_F0   = 4;
  localparam int SB_F1   = 5;
  localparam int SB_PINT = 6;

  typedef enum logic [2:0] {
    TGT_PHI,
    TGT_PLO,
    TGT_STAT,
    TGT_RAM,
    TGT_DEV
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int DEV_IDX_W = 4
) (
  input  logic [DEV_IDX_W:0]   addr,
  output tgt_e                 tgt,
  output logic [DEV_IDX_W-1:0] idx
);
  // priority: device window, RAM, status, pointer low, pointer high
  always_comb begin
    idx = addr[DEV_IDX_W-1:0];
    if (addr[DEV_IDX_W])  tgt = TGT_DEV;
    else if (addr[2])     tgt = TGT_RAM;
    else if (addr[1])     tgt = TGT_STAT;
    else if (addr[0])     tgt = TGT_PLO;
    else                  tgt = TGT_PHI;
  end
endmodule

// File: rtl/mbx_ptr.sv
module mbx_ptr
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [BYTE_W-1:0] data,
  input  logic              inc,
  output logic [PTR_W-1:0]  ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (ld_hi) ptr <= {data, ptr[BYTE_W-1:0]};
    else if (ld_lo) ptr <= {ptr[PTR_W-1:BYTE_W], data};
    else if (inc)   ptr <= ptr + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo) |=> (ptr == $past(ptr) + 1'b1)); // R3
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_clr,
  input  logic              wr_stat,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              emb_wr,
  input  logic [BYTE_W-1:0] emb_wdata,
  input  logic              periph_int,
  input  logic              bypass,
  output logic [BYTE_W-1:0] stat_rd,
  output logic [BYTE_W-1:0] emb_rd,
  output logic              ainc,
  output logic              cpu_reset_n,
  output logic              host_irq,
  output logic              doorbell
);
  logic       run_q, ainc_q, pint_q, irq_q, bell_q;
  logic [1:0] flg_q, flg_clr, flg_set, flg_nxt;
  logic [BYTE_W-1:0] stat_raw;

  always_comb begin
    flg_clr = wr_stat ? wdata[SB_F1:SB_F0] : 2'b00;
    flg_set = emb_wr  ? emb_wdata[3:2]    : 2'b00;
    flg_nxt = (flg_q & ~flg_clr) | flg_set;   // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ainc_q <= 1'b0;
      pint_q <= 1'b0;
      flg_q  <= 2'b00;
      irq_q  <= 1'b0;
      bell_q <= 1'b0;
    end else begin
      pint_q <= periph_int;
      bell_q <= wr_stat && wdata[SB_BELL] && !port_clr;
      if (port_clr) begin
        run_q <= 1'b0;
        flg_q <= 2'b00;
        irq_q <= 1'b0;
      end else begin
        if (wr_stat) begin
          run_q  <= wdata[SB_RUN];
          ainc_q <= wdata[SB_AINC];
        end
        flg_q <= flg_nxt;
        irq_q <= |flg_nxt;
      end
    end
  end

  always_comb begin
    stat_raw = {1'b1, pint_q, flg_q, 1'b0, run_q, ainc_q, 1'b0};
    stat_rd  = bypass ? (stat_raw | 8'h01) : {2'b10, stat_raw[5:0]};
    emb_rd   = {4'b0000, flg_q, 2'b00};
  end

  assign ainc        = ainc_q;
  assign cpu_reset_n = run_q;
  assign host_irq    = irq_q;
  assign doorbell    = bell_q;

  AST_BELL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(wr_stat && wdata[SB_BELL])); // R5
  AST_RUN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset_n) |-> $past(wr_stat && wdata[SB_RUN])); // R4
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(emb_wr && (emb_wdata[3:2] != 2'b00))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (emb_wr && emb_wdata[2] && !port_clr) |=> emb_rd[2]); // R8
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int DEV_IDX_W = 4,
  localparam int ADDR_W   = DEV_IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_clr,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BYTE_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [BYTE_W-1:0]    rsp_data,
  output logic                 ram_valid,
  input  logic                 ram_ready,
  output logic                 ram_we,
  output logic [PTR_W-1:0]     ram_addr,
  output logic [BYTE_W-1:0]    ram_wdata,
  input  logic [BYTE_W-1:0]    ram_rdata,
  output logic                 per_valid,
  output logic                 per_we,
  output logic [DEV_IDX_W-1:0] per_idx,
  output logic [BYTE_W-1:0]    per_wdata,
  input  logic [BYTE_W-1:0]    per_rdata,
  input  logic                 bypass,
  input  logic                 periph_int,
  input  logic                 emb_wr,
  input  logic [BYTE_W-1:0]    emb_wdata,
  output logic [BYTE_W-1:0]    emb_rd,
  output logic                 emb_doorbell,
  output logic                 cpu_reset_n,
  output logic                 host_irq
);
  st_e                  st_q;
  tgt_e                 tgt;
  logic [DEV_IDX_W-1:0] dec_idx;
  logic [PTR_W-1:0]     ptr;
  logic [BYTE_W-1:0]    stat_rd;
  logic                 ainc;
  logic                 accept, wr_stat, ld_hi, ld_lo, ext_fire, ptr_inc;
  logic                 hold_we, hold_dev;
  logic [BYTE_W-1:0]    hold_wdata;
  logic [DEV_IDX_W-1:0] hold_idx;
  logic                 rsp_v_q;
  logic [BYTE_W-1:0]    rsp_d_q;

  mbx_decode #(.DEV_IDX_W(DEV_IDX_W)) u_dec (
    .addr (req_addr),
    .tgt  (tgt),
    .idx  (dec_idx)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_stat   = accept && req_we && (tgt == TGT_STAT);
  assign ld_hi     = accept && req_we && (tgt == TGT_PHI);
  assign ld_lo     = accept && req_we && (tgt == TGT_PLO);
  assign ext_fire  = (st_q == ST_ISSUE) && (hold_dev || ram_ready);
  assign ptr_inc   = ext_fire && !hold_dev && ainc;

  mbx_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_hi (ld_hi),
    .ld_lo (ld_lo),
    .data  (req_wdata),
    .inc   (ptr_inc),
    .ptr   (ptr)
  );

  mbx_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_clr    (port_clr),
    .wr_stat     (wr_stat),
    .wdata       (req_wdata),
    .emb_wr      (emb_wr),
    .emb_wdata   (emb_wdata),
    .periph_int  (periph_int),
    .bypass      (bypass),
    .stat_rd     (stat_rd),
    .emb_rd      (emb_rd),
    .ainc        (ainc),
    .cpu_reset_n (cpu_reset_n),
    .host_irq    (host_irq),
    .doorbell    (emb_doorbell)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      hold_we    <= 1'b0;
      hold_dev   <= 1'b0;
      hold_wdata <= '0;
      hold_idx   <= '0;
      rsp_v_q    <= 1'b0;
      rsp_d_q    <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          unique case (tgt)
            TGT_PHI: if (!req_we) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= ptr[PTR_W-1:BYTE_W];
            end
            TGT_PLO: if (!req_we) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= ptr[BYTE_W-1:0];
            end
            TGT_STAT: if (!req_we) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= stat_rd;
            end
            TGT_RAM: begin
              hold_we    <= req_we;
              hold_wdata <= req_wdata;
              hold_dev   <= 1'b0;
              st_q       <= ST_ISSUE;
            end
            TGT_DEV: begin
              if (bypass) begin
                hold_we    <= req_we;
                hold_wdata <= req_wdata;
                hold_idx   <= dec_idx;
                hold_dev   <= 1'b1;
                st_q       <= ST_ISSUE;
              end else if (!req_we) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= '0;
              end
            end
            default: ;
          endcase
        end
        ST_ISSUE: if (ext_fire) st_q <= hold_we ? ST_IDLE : ST_WAIT;
        ST_WAIT: begin
          rsp_v_q <= 1'b1;
          rsp_d_q <= hold_dev ? per_rdata : ram_rdata;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
  assign ram_valid = (st_q == ST_ISSUE) && !hold_dev;
  assign ram_we    = hold_we;
  assign ram_addr  = ptr;
  assign ram_wdata = hold_wdata;
  assign per_valid = (st_q == ST_ISSUE) && hold_dev;
  assign per_we    = hold_we;
  assign per_idx   = hold_idx;
  assign per_wdata = hold_wdata;

  AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_ready) |=> (ram_valid && $stable(ram_addr) && $stable(ram_wdata))); // R12
  AST_DEV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_valid) |-> $past(bypass)); // R10
endmodule

// File: tb/mbx_host_port_tb.sv
`timescale 1ns/1ps
module mbx_host_port_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, port_clr;
  logic       req_valid, req_ready, req_we;
  logic [4:0] req_addr;
  logic [7:0] req_wdata, rsp_data;
  logic       rsp_valid;
  logic       ram_valid, ram_ready, ram_we;
  logic [15:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic       per_valid, per_we;
  logic [3:0] per_idx;
  logic [7:0] per_wdata, per_rdata;
  logic       bypass, periph_int, emb_wr;
  logic [7:0] emb_wdata, emb_rd;
  logic       emb_doorbell, cpu_reset_n, host_irq;

  mbx_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .port_clr(port_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .per_valid(per_valid), .per_we(per_we), .per_idx(per_idx),
    .per_wdata(per_wdata), .per_rdata(per_rdata),
    .bypass(bypass), .periph_int(periph_int),
    .emb_wr(emb_wr), .emb_wdata(emb_wdata), .emb_rd(emb_rd),
    .emb_doorbell(emb_doorbell), .cpu_reset_n(cpu_reset_n), .host_irq(host_irq)
  );

  // memory and peripheral models
  logic [7:0] mem [256];
  logic [7:0] preg [16];
  logic       ram_stall = 1'b0;
  assign ram_ready = !ram_stall;
  always @(posedge clk) begin
    if (ram_valid && ram_ready) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr[7:0]];
    end
    if (per_valid) begin
      if (per_we) preg[per_idx] <= per_wdata;
      else        per_rdata <= preg[per_idx];
    end
  end

  int bell_cnt = 0;
  always @(posedge clk) if (rst_n && emb_doorbell) bell_cnt <= bell_cnt + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic [4:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = 8'hEE;
    if (!we) begin
      for (int i = 0; i < 20; i++) begin
        if (rsp_valid) begin rd = rsp_data; break; end
        @(negedge clk);
      end
    end
  endtask

  task automatic emb_set(input logic [7:0] d);
    @(negedge clk);
    emb_wr = 1'b1; emb_wdata = d;
    @(negedge clk);
    emb_wr = 1'b0;
  endtask

  // {we, addr[4:0], wdata[7:0], chk, exp[7:0]}
  localparam int NV = 25;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 5'h00, 8'h12, 1'b0, 8'h00},
    {1'b1, 5'h01, 8'h34, 1'b0, 8'h00},
    {1'b0, 5'h00, 8'h00, 1'b1, 8'h12},  // R2 high byte
    {1'b0, 5'h01, 8'h00, 1'b1, 8'h34},  // R2 low byte
    {1'b1, 5'h02, 8'h06, 1'b0, 8'h00},  // run + auto-increment
    {1'b0, 5'h02, 8'h00, 1'b1, 8'h86},  // R9 R4 normal-mode format
    {1'b1, 5'h04, 8'hA5, 1'b0, 8'h00},
    {1'b1, 5'h04, 8'h5A, 1'b0, 8'h00},
    {1'b0, 5'h01, 8'h00, 1'b1, 8'h36},  // R3 two increments
    {1'b1, 5'h01, 8'h34, 1'b0, 8'h00},
    {1'b0, 5'h04, 8'h00, 1'b1, 8'hA5},  // R3 read at pointer
    {1'b0, 5'h04, 8'h00, 1'b1, 8'h5A},  // R3
    {1'b0, 5'h01, 8'h00, 1'b1, 8'h36},  // R3 reads also step
    {1'b1, 5'h02, 8'h04, 1'b0, 8'h00},  // auto-increment off
    {1'b1, 5'h01, 8'h40, 1'b0, 8'h00},
    {1'b1, 5'h04, 8'h77, 1'b0, 8'h00},
    {1'b0, 5'h01, 8'h00, 1'b1, 8'h40},  // R3 no step
    {1'b0, 5'h04, 8'h00, 1'b1, 8'h77},  // R3
    {1'b1, 5'h05, 8'h11, 1'b0, 8'h00},  // R1 RAM over pointer low
    {1'b0, 5'h01, 8'h00, 1'b1, 8'h40},  // R1 pointer untouched
    {1'b0, 5'h06, 8'h00, 1'b1, 8'h11},  // R1 RAM over status
    {1'b0, 5'h03, 8'h00, 1'b1, 8'h84},  // R1 status over pointer low
    {1'b1, 5'h13, 8'h99, 1'b0, 8'h00},  // R10 dropped in normal mode
    {1'b0, 5'h13, 8'h00, 1'b1, 8'h00},  // R10 reads 0
    {1'b0, 5'h17, 8'h00, 1'b1, 8'h00}   // R1 device window over RAM
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) preg[i] = 8'h00;
    rst_n = 1'b0; port_clr = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; bypass = 1'b0; periph_int = 1'b0;
    emb_wr = 1'b0; emb_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R11
    check("R11 cpu_reset_n", cpu_reset_n, 0);
    check("R11 host_irq", host_irq, 0);
    check("R11 req_ready", req_ready, 1);
    host_op(0, 5'h02, 0, rd); check("R11 status", rd, 8'h80);
    host_op(0, 5'h00, 0, rd); check("R11 pointer", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i][22], VEC[i][21:17], VEC[i][16:9], rd);
      if (VEC[i][8]) check($sformatf("table %0d", i), rd, VEC[i][7:0]);
    end

    // doorbell, R5
    check("R5 no bell", bell_cnt, 0);
    host_op(1, 5'h02, 8'h0C, rd);
    @(negedge clk);
    check("R5 bell once", bell_cnt, 1);
    host_op(0, 5'h02, 0, rd); check("R5 bit3 not stored", rd, 8'h84);

    // cpu reset, R4
    check("R4 released", cpu_reset_n, 1);
    host_op(1, 5'h02, 8'h00, rd);
    check("R4 held", cpu_reset_n, 0);
    host_op(1, 5'h02, 8'h06, rd);
    check("R4 released again", cpu_reset_n, 1);

    // flags, R6 R7
    emb_set(8'h0C);
    check("R7 irq", host_irq, 1);
    check("R7 emb_rd", emb_rd, 8'h0C);
    host_op(0, 5'h02, 0, rd); check("R9 flags in status", rd, 8'hB6);
    host_op(1, 5'h02, 8'h16, rd);
    check("R6 irq kept", host_irq, 1);
    check("R6 one cleared", emb_rd, 8'h08);
    host_op(1, 5'h02, 8'h26, rd);
    check("R6 irq low", host_irq, 0);
    check("R6 all clear", emb_rd, 8'h00);
    emb_set(8'h00);
    check("R7 zero sets none", host_irq, 0);

    // set wins, R8
    emb_set(8'h04);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 5'h02; req_wdata = 8'h16;
    emb_wr = 1'b1; emb_wdata = 8'h04;
    @(negedge clk);
    req_valid = 1'b0; emb_wr = 1'b0;
    check("R8 set wins", emb_rd, 8'h04);
    check("R8 irq", host_irq, 1);

    // status format and bypass, R9 R10
    bypass = 1'b1; periph_int = 1'b1;
    repeat (2) @(negedge clk);
    host_op(0, 5'h02, 0, rd); check("R9 bypass format", rd, 8'hD7);
    bypass = 1'b0;
    host_op(0, 5'h02, 0, rd); check("R9 normal format", rd, 8'h96);
    bypass = 1'b1;
    host_op(1, 5'h13, 8'h99, rd);
    @(negedge clk);
    check("R10 forwarded write", preg[3], 8'h99);
    host_op(0, 5'h13, 0, rd); check("R10 forwarded read", rd, 8'h99);
    bypass = 1'b0; periph_int = 1'b0;

    // controller clear, R11
    emb_set(8'h08);
    @(negedge clk); port_clr = 1'b1;
    @(negedge clk); port_clr = 1'b0;
    check("R11 clr irq", host_irq, 0);
    check("R11 clr cpu", cpu_reset_n, 0);
    host_op(0, 5'h02, 0, rd); check("R11 clr keeps", rd, 8'h82);

    // wrap, R3
    host_op(1, 5'h02, 8'h06, rd);
    host_op(1, 5'h00, 8'hFF, rd);
    host_op(1, 5'h01, 8'hFF, rd);
    host_op(1, 5'h04, 8'h3C, rd);
    host_op(0, 5'h00, 0, rd); check("R3 wrap hi", rd, 8'h00);
    host_op(0, 5'h01, 0, rd); check("R3 wrap lo", rd, 8'h00);
    host_op(1, 5'h00, 8'hFF, rd);
    host_op(1, 5'h01, 8'hFF, rd);
    host_op(0, 5'h04, 0, rd); check("R3 data at FFFF", rd, 8'h3C);

    // stalled memory, R12 R3
    host_op(1, 5'h00, 8'h00, rd);
    host_op(1, 5'h01, 8'h10, rd);
    ram_stall = 1'b1;
    host_op(1, 5'h04, 8'h5E, rd);
    repeat (4) @(negedge clk);
    check("R12 valid held", ram_valid, 1);
    check("R12 ready low", req_ready, 0);
    check("R12 addr held", ram_addr, 16'h0010);
    ram_stall = 1'b0;
    host_op(0, 5'h01, 0, rd); check("R3 single step", rd, 8'h11);
    host_op(1, 5'h01, 8'h10, rd);
    host_op(0, 5'h04, 0, rd); check("R12 data", rd, 8'h5E);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule